// File: doc/BRIEF.md
# Virtual-Time Clock Source and Delayed Flip-Flop Model

This block models a clocked storage element on a virtual time base. Every cycle of the fast emulation clock stands for one time unit (TU) of virtual time. From that fast clock the block derives a slow clock for the design under emulation. The period of that slow clock is a run-time whole number of TUs.

The block also contains a D flip-flop model driven by the slow clock. The model captures its data input on the slow clock's rising edge. It does not show the captured word at its output on that edge. The word appears only after a programmable clock-to-output delay, also counted in TUs. A netlist can then be emulated with flip-flop timing expressed in virtual time, independent of the fabric's own timing. Setup and hold checks are not part of the block.

Top module: `vt_dff_emu`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `emu_clk` and `q_out` are 0 after that edge. The first rising edge of `clk` with `rst` low drives `emu_clk` to 1.
- R2: With `period_tu` held at P, `emu_clk` repeats with a period of exactly P cycles of `clk`.
- R3: Within each period, `emu_clk` is 1 for floor(P/2) cycles and then 0 for the remaining P - floor(P/2) cycles. The 0-to-1 transition marks the start of a period.
- R4: The word captured is the value of `d_in` at the rising edge of `clk` that drives `emu_clk` from 0 to 1.
- R5: With `c2q_tu` = C, `q_out` takes the captured word exactly C rising edges of `clk` after the capture edge. When C = 0, `q_out` updates on the capture edge itself.
- R6: At all other times `q_out` holds its value. Changes of `d_in` between capture edges have no effect on `q_out`.
- R7: Settings with P >= 2 and C <= P - 1 are legal. For these, each captured word reaches `q_out` before the next capture. This includes the boundary C = P - 1 and the widest period that `period_tu` can express.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast emulation clock; one cycle equals one TU |
| rst | input | 1 | Synchronous active-high reset |
| period_tu | input | TU_W | Emulated clock period in TUs (>= 2) |
| c2q_tu | input | TU_W | Clock-to-output delay in TUs (<= period_tu - 1) |
| d_in | input | DATA_W | Data input of the emulated flip-flop |
| emu_clk | output | 1 | Derived emulated-design clock |
| q_out | output | DATA_W | Delayed flip-flop output |

## Verification
The hardest case to reach is a delay of P - 1 TUs. There, a captured word is released on the last cycle before the next capture, so an off-by-one in the countdown either loses the word or collides with the next capture. The stimulus runs this boundary at small and at the widest periods. `d_in` changes on every cycle, so any capture on the wrong cycle shows up as a mismatch. One segment is cut short by reset while a word is still pending, to confirm that the pending word is dropped.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic {
    SLOT_IDLE  = 1'b0,
    SLOT_ARMED = 1'b1
  } slot_e;
endpackage

// File: rtl/vt_period_gen.sv
module vt_period_gen #(
  parameter int TU_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TU_W-1:0] period_tu,
  output logic            emu_clk,
  output logic            rise_tick
);
  logic [TU_W-1:0] phase;
  logic [TU_W-1:0] high_len;
  logic            at_end;

  assign high_len  = period_tu >> 1;
  assign at_end    = (phase >= period_tu - 1'b1);
  assign rise_tick = !rst && (phase == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      emu_clk <= 1'b0;
    end else begin
      phase   <= at_end ? '0 : phase + 1'b1;
      emu_clk <= (phase < high_len);
    end
  end

  // R1: reset forces the emulated clock low
  a_r1_clk_reset: assert property (@(posedge clk) rst |=> !emu_clk);
  // R2: the phase counter returns to zero after the last TU of a period
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (phase == '0));
  // R3: the start of a period raises the emulated clock
  a_r3_rise_start: assert property (@(posedge clk) disable iff (rst)
    rise_tick |=> emu_clk);
endmodule

// File: rtl/vt_c2q_delay.sv
module vt_c2q_delay
  import vt_pkg::*;
#(
  parameter int TU_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [TU_W-1:0]   c2q_tu,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] q_out
);
  slot_e             slot;
  logic [TU_W-1:0]   remain;
  logic [DATA_W-1:0] held;
  logic              release_now;

  assign release_now = (slot == SLOT_ARMED) && (remain == {{(TU_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= SLOT_IDLE;
      remain <= '0;
      held   <= '0;
      q_out  <= '0;
    end else if (capture) begin
      if (c2q_tu == '0) begin
        q_out <= d_in;
        slot  <= SLOT_IDLE;
      end else begin
        held   <= d_in;
        remain <= c2q_tu;
        slot   <= SLOT_ARMED;
      end
    end else if (release_now) begin
      q_out <= held;
      slot  <= SLOT_IDLE;
    end else if (slot == SLOT_ARMED) begin
      remain <= remain - 1'b1;
    end
  end

  // R1: reset clears the flip-flop output
  a_r1_q_reset: assert property (@(posedge clk) rst |=> (q_out == '0));
  // R5: zero delay shows the sampled word on the capture edge
  a_r5_zero_delay: assert property (@(posedge clk) disable iff (rst)
    (capture && c2q_tu == '0) |=> (q_out == $past(d_in)));
  // R5: a nonzero delay arms the slot
  a_r5_arm: assert property (@(posedge clk) disable iff (rst)
    (capture && c2q_tu != '0) |=> (slot == SLOT_ARMED));
  // R6: with no capture and no release the output holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!capture && !release_now) |=> $stable(q_out));
endmodule

// File: rtl/vt_dff_emu.sv
module vt_dff_emu #(
  parameter int TU_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TU_W-1:0]   period_tu,
  input  logic [TU_W-1:0]   c2q_tu,
  input  logic [DATA_W-1:0] d_in,
  output logic              emu_clk,
  output logic [DATA_W-1:0] q_out
);
  logic rise_tick;

  vt_period_gen #(.TU_W(TU_W)) u_period (
    .clk       (clk),
    .rst       (rst),
    .period_tu (period_tu),
    .emu_clk   (emu_clk),
    .rise_tick (rise_tick)
  );

  vt_c2q_delay #(.TU_W(TU_W), .DATA_W(DATA_W)) u_delay (
    .clk     (clk),
    .rst     (rst),
    .capture (rise_tick),
    .c2q_tu  (c2q_tu),
    .d_in    (d_in),
    .q_out   (q_out)
  );

  // R4: capture happens exactly when the emulated clock goes high
  a_r4_capture_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(emu_clk) |-> $past(rise_tick));
endmodule

// File: tb/vt_dff_emu_tb.sv
module vt_dff_emu_tb;
  localparam int TU_W   = 8;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [TU_W-1:0]   period_tu = 8'd5;
  logic [TU_W-1:0]   c2q_tu = 8'd2;
  logic [DATA_W-1:0] d_in = '0;
  logic              emu_clk;
  logic [DATA_W-1:0] q_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  vt_dff_emu #(.TU_W(TU_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .period_tu(period_tu), .c2q_tu(c2q_tu),
    .d_in(d_in), .emu_clk(emu_clk), .q_out(q_out)
  );

  // behavioural reference model
  int                cur_p = 5;
  int                cur_c = 2;
  int                n = 0;
  bit                m_clk = 1'b0;
  logic [DATA_W-1:0] m_q = '0;
  bit                m_upd = 1'b0;
  bit                m_rst = 1'b1;
  int                due_q[$];
  logic [DATA_W-1:0] val_q[$];
  string             seg_tag = "R2";

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      n = 0; m_clk = 1'b0; m_q = '0; m_upd = 1'b0; m_rst = 1'b1;
      due_q.delete(); val_q.delete();
    end else begin
      int ph;
      m_rst = 1'b0;
      m_upd = 1'b0;
      ph = n % cur_p;
      if (ph == 0) begin
        due_q.push_back(n + cur_c);
        val_q.push_back(d_in);
      end
      if (due_q.size() > 0 && due_q[0] == n) begin
        void'(due_q.pop_front());
        m_q = val_q.pop_front();
        m_upd = 1'b1;
      end
      m_clk = (ph < cur_p / 2);
      n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_rst) begin
      chk(emu_clk == 1'b0, "R1 emu_clk in reset", emu_clk, 0);
      chk(q_out == '0, "R1 q_out in reset", q_out, 0);
    end else begin
      chk(emu_clk == m_clk, {seg_tag, " R3 emu_clk"}, emu_clk, m_clk);
      if (m_upd)
        chk(q_out == m_q, {seg_tag, " R4 R5 q_out update"}, q_out, m_q);
      else
        chk(q_out == m_q, {seg_tag, " R6 q_out hold"}, q_out, m_q);
    end
  end

  task automatic run_seg(input int p, input int c, input int ncyc, input string tag);
    @(negedge clk);
    rst = 1'b1;
    period_tu = p[TU_W-1:0];
    c2q_tu = c[TU_W-1:0];
    cur_p = p;
    cur_c = c;
    seg_tag = tag;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (ncyc) begin
      @(negedge clk);
      d_in = DATA_W'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run_seg(5, 2, 60, "R2");
    run_seg(2, 1, 40, "R7");
    run_seg(2, 0, 40, "R5");
    run_seg(7, 6, 70, "R7");
    run_seg(16, 0, 80, "R2");
    run_seg(3, 2, 45, "R7");
    run_seg(6, 3, 50, "R2");
    run_seg(9, 8, 12, "R1");
    run_seg(4, 1, 40, "R1");
    run_seg(255, 254, 800, "R7");
    run_seg(255, 0, 300, "R2");
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule